// File: doc/BRIEF.md
# Return-from-Exception Status Updater

This block computes the processor state that results from returning out of an exception handler or out of a non-maskable interrupt handler. The status word holds the saved mode and flag field in its upper bits. A return shifts that field down to the live position. The two top bits of the word stay in place. Two flag rules then apply on top of the shift: the pending flag and the NMI-mask flag.

When the restored mode is user mode, the stack pointers are swapped. The current stack pointer is saved as the kernel stack pointer, and the stack pointer is loaded from the user stack pointer.

The execute stage drives the current status word, the stack pointer, the user stack pointer and a one-bit opcode selecting a plain return or an NMI return. It pulses an execute strobe for one cycle. The new values appear on the registered outputs after the next rising clock edge.

Top module: `exc_return_unit`

## Requirements
- R1: After reset, `statusOut`, `spOut` and `kspOut` are all zero.
- R2: On an executed return, bits [17:0] of the new status word are old bits [27:10], before the flag rules are applied.
- R3: On an executed return, new bits [31:30] equal old bits [31:30]. Old bits [29:28] are discarded, and new bits [29:18] are zero apart from the flag rules.
- R4: For both opcodes, the pending flag (default bit 7) is forced to 1 when the old restart flag (default bit 8) was 0. Otherwise the pending flag keeps the shifted value, which is old bit 17.
- R5: An NMI return (`isRfn` = 1) always sets the NMI-mask flag (default bit 9).
- R6: A plain return (`isRfn` = 0) leaves the NMI-mask flag at its shifted value, which is old bit 19.
- R7: When the user flag (default bit 6) of the shifted word is 1, `kspOut` takes the incoming `spIn` and `spOut` takes `uspIn`.
- R8: When the user flag of the shifted word is 0, `spOut` takes `spIn` and `kspOut` keeps its previous value.
- R9: While `execEn` is 0, all three outputs hold their values whatever the other inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| execEn | input | 1 | One-cycle strobe that executes a return |
| isRfn | input | 1 | Opcode select: 0 = plain return, 1 = NMI return |
| statusIn | input | 32 | Current status word |
| spIn | input | 32 | Current stack pointer |
| uspIn | input | 32 | Saved user stack pointer |
| statusOut | output | 32 | Updated status word |
| spOut | output | 32 | Updated stack pointer |
| kspOut | output | 32 | Saved kernel stack pointer |

## Verification
An all-ones word, with the restart flag set, checks the full shift and the user-mode swap together. A zero word, and a word carrying only the restart flag, tell the forced pending flag apart from a pending flag that comes through the shift. Plain and NMI returns on the same word show that the NMI-mask flag is forced only by the NMI return. A word whose bit 19 is set shows that the plain return carries the shifted mask bit through.

Words with bits [31:28] set separate the preserved top pair from the discarded pair. A non-swapping return that follows a swapping one shows that the kernel stack pointer holds its value. Changing inputs while the strobe is low shows that nothing moves.

// File: rtl/excret_pkg.sv
package excret_pkg;

  typedef enum logic {
    OP_RFE = 1'b0,
    OP_RFN = 1'b1
  } retOp_e;

  // Strobes issued by control to the datapath each cycle.
  typedef struct packed {
    logic capture;      // update the status word
    logic swapStack;    // user mode entered: swap stack pointers
    logic forcePend;    // force the pending flag to one
    logic forceNmiMask; // force the NMI-mask flag to one
  } retCtrl_t;

endpackage

// File: rtl/excret_ctrl.sv
module excret_ctrl
  import excret_pkg::*;
(
  input  logic     execEn,
  input  logic     isRfn,
  input  logic     oldRFlag,
  input  logic     shiftedUFlag,
  output retCtrl_t ctrl
);

  retOp_e opSel;

  always_comb begin
    opSel = retOp_e'(isRfn);
    ctrl.capture      = execEn;
    ctrl.swapStack    = execEn && shiftedUFlag;
    ctrl.forcePend    = execEn && !oldRFlag;
    ctrl.forceNmiMask = execEn && (opSel == OP_RFN);
  end

endmodule

// File: rtl/excret_dp.sv
module excret_dp
  import excret_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int KEEP_HI   = 2,
  parameter int GAP_W     = 2,
  parameter int POP_SHIFT = 10,
  parameter int U_BIT     = 6,
  parameter int P_BIT     = 7,
  parameter int R_BIT     = 8,
  parameter int M_BIT     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  retCtrl_t          ctrl,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] uspIn,
  output logic              oldRFlag,
  output logic              shiftedUFlag,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] kspOut
);

  localparam int FIELD_W = DATA_W - KEEP_HI - GAP_W;
  localparam logic [DATA_W-1:0] KEEP_MASK =
    {{KEEP_HI{1'b1}}, {(DATA_W - KEEP_HI){1'b0}}};
  localparam logic [DATA_W-1:0] FIELD_MASK =
    {{(KEEP_HI + GAP_W){1'b0}}, {FIELD_W{1'b1}}};

  logic [DATA_W-1:0] shiftedWord;
  logic [DATA_W-1:0] newStatus;

  assign shiftedWord  = (statusIn & KEEP_MASK) | ((statusIn & FIELD_MASK) >> POP_SHIFT);
  assign oldRFlag     = statusIn[R_BIT];
  assign shiftedUFlag = shiftedWord[U_BIT];

  // Overlay the forced flags on the shifted word, bit by bit.
  for (genvar gi = 0; gi < DATA_W; gi++) begin : g_flagMerge
    if (gi == P_BIT && gi == M_BIT) begin : g_both
      assign newStatus[gi] = shiftedWord[gi] | ctrl.forcePend | ctrl.forceNmiMask;
    end else if (gi == P_BIT) begin : g_pend
      assign newStatus[gi] = shiftedWord[gi] | ctrl.forcePend;
    end else if (gi == M_BIT) begin : g_nmi
      assign newStatus[gi] = shiftedWord[gi] | ctrl.forceNmiMask;
    end else begin : g_pass
      assign newStatus[gi] = shiftedWord[gi];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusOut <= '0;
      spOut     <= '0;
      kspOut    <= '0;
    end else if (ctrl.capture) begin
      statusOut <= newStatus;
      if (ctrl.swapStack) begin
        kspOut <= spIn;
        spOut  <= uspIn;
      end else begin
        spOut  <= spIn;
      end
    end
  end

endmodule

// File: rtl/exc_return_unit.sv
module exc_return_unit
  import excret_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int KEEP_HI   = 2,
  parameter int GAP_W     = 2,
  parameter int POP_SHIFT = 10,
  parameter int U_BIT     = 6,
  parameter int P_BIT     = 7,
  parameter int R_BIT     = 8,
  parameter int M_BIT     = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              execEn,
  input  logic              isRfn,
  input  logic [DATA_W-1:0] statusIn,
  input  logic [DATA_W-1:0] spIn,
  input  logic [DATA_W-1:0] uspIn,
  output logic [DATA_W-1:0] statusOut,
  output logic [DATA_W-1:0] spOut,
  output logic [DATA_W-1:0] kspOut
);

  retCtrl_t ctrl;
  logic     oldRFlag;
  logic     shiftedUFlag;

  excret_ctrl i_ctrl (
    .execEn       (execEn),
    .isRfn        (isRfn),
    .oldRFlag     (oldRFlag),
    .shiftedUFlag (shiftedUFlag),
    .ctrl         (ctrl)
  );

  excret_dp #(
    .DATA_W    (DATA_W),
    .KEEP_HI   (KEEP_HI),
    .GAP_W     (GAP_W),
    .POP_SHIFT (POP_SHIFT),
    .U_BIT     (U_BIT),
    .P_BIT     (P_BIT),
    .R_BIT     (R_BIT),
    .M_BIT     (M_BIT)
  ) i_dp (
    .clk          (clk),
    .rstN         (rstN),
    .ctrl         (ctrl),
    .statusIn     (statusIn),
    .spIn         (spIn),
    .uspIn        (uspIn),
    .oldRFlag     (oldRFlag),
    .shiftedUFlag (shiftedUFlag),
    .statusOut    (statusOut),
    .spOut        (spOut),
    .kspOut       (kspOut)
  );

endmodule

// File: rtl/exc_return_unit_chk.sv
module exc_return_unit_chk #(
  parameter int DATA_W    = 32,
  parameter int KEEP_HI   = 2,
  parameter int POP_SHIFT = 10,
  parameter int U_BIT     = 6,
  parameter int P_BIT     = 7,
  parameter int R_BIT     = 8,
  parameter int M_BIT     = 9
) (
  input logic              clk,
  input logic              rstN,
  input logic              execEn,
  input logic              isRfn,
  input logic [DATA_W-1:0] statusIn,
  input logic [DATA_W-1:0] spIn,
  input logic [DATA_W-1:0] uspIn,
  input logic [DATA_W-1:0] statusOut,
  input logic [DATA_W-1:0] spOut,
  input logic [DATA_W-1:0] kspOut
);

  // The user flag after the shift comes from this incoming bit.
  localparam int U_SRC = U_BIT + POP_SHIFT;

  a_r9_hold: assert property (@(posedge clk) disable iff (!rstN)
    !execEn |=> ($stable(statusOut) && $stable(spOut) && $stable(kspOut)));

  a_r3_top_kept: assert property (@(posedge clk) disable iff (!rstN)
    execEn |=> (statusOut[DATA_W-1:DATA_W-KEEP_HI] == $past(statusIn[DATA_W-1:DATA_W-KEEP_HI])));

  a_r4_pend_forced: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && !statusIn[R_BIT]) |=> statusOut[P_BIT]);

  a_r5_rfn_mask: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && isRfn) |=> statusOut[M_BIT]);

  a_r7_swap: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && statusIn[U_SRC]) |=> ((spOut == $past(uspIn)) && (kspOut == $past(spIn))));

  a_r8_no_swap: assert property (@(posedge clk) disable iff (!rstN)
    (execEn && !statusIn[U_SRC]) |=> ((spOut == $past(spIn)) && $stable(kspOut)));

endmodule

bind exc_return_unit exc_return_unit_chk #(
  .DATA_W    (DATA_W),
  .KEEP_HI   (KEEP_HI),
  .POP_SHIFT (POP_SHIFT),
  .U_BIT     (U_BIT),
  .P_BIT     (P_BIT),
  .R_BIT     (R_BIT),
  .M_BIT     (M_BIT)
) i_exc_return_unit_chk (
  .clk       (clk),
  .rstN      (rstN),
  .execEn    (execEn),
  .isRfn     (isRfn),
  .statusIn  (statusIn),
  .spIn      (spIn),
  .uspIn     (uspIn),
  .statusOut (statusOut),
  .spOut     (spOut),
  .kspOut    (kspOut)
);

// File: tb/test_exc_return_unit.sv
module test_exc_return_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        execEn = 1'b0;
  logic        isRfn = 1'b0;
  logic [31:0] statusIn = '0;
  logic [31:0] spIn = '0;
  logic [31:0] uspIn = '0;
  logic [31:0] statusOut;
  logic [31:0] spOut;
  logic [31:0] kspOut;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  exc_return_unit i_exc_return_unit (
    .clk       (clk),
    .rstN      (rstN),
    .execEn    (execEn),
    .isRfn     (isRfn),
    .statusIn  (statusIn),
    .spIn      (spIn),
    .uspIn     (uspIn),
    .statusOut (statusOut),
    .spOut     (spOut),
    .kspOut    (kspOut)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  // Expected status word from the requirements: shift, then flag rules.
  function automatic logic [31:0] model(input logic rfn, input logic [31:0] s);
    logic [31:0] w;
    w = (s & 32'hC000_0000) | ((s & 32'h0FFF_FFFF) >> 10);
    if (!s[8]) w[7] = 1'b1;
    if (rfn) w[9] = 1'b1;
    return w;
  endfunction

  task automatic runOp(input logic rfn, input logic [31:0] s,
                       input logic [31:0] sp, input logic [31:0] usp);
    @(negedge clk);
    isRfn = rfn; statusIn = s; spIn = sp; uspIn = usp; execEn = 1'b1;
    @(negedge clk);
    execEn = 1'b0;
  endtask

  task automatic tReset();
    check("R1 status", statusOut, 32'h0);
    check("R1 sp", spOut, 32'h0);
    check("R1 ksp", kspOut, 32'h0);
  endtask

  task automatic tFullShiftSwap();
    runOp(1'b0, 32'hFFFF_FFFF, 32'h1000_0040, 32'h2000_0080);
    check("R2 full shift", statusOut, 32'hC003_FFFF);
    check("R2 model", statusOut, model(1'b0, 32'hFFFF_FFFF));
    check("R7 sp from usp", spOut, 32'h2000_0080);
    check("R7 ksp from sp", kspOut, 32'h1000_0040);
  endtask

  task automatic tPendForced();
    runOp(1'b0, 32'h0000_0000, 32'h3000_0010, 32'h4000_0020);
    check("R4 pend forced", statusOut, 32'h0000_0080);
    check("R8 sp kept", spOut, 32'h3000_0010);
    check("R8 ksp held", kspOut, 32'h1000_0040);
  endtask

  task automatic tPendNotForced();
    runOp(1'b0, 32'h0000_0100, 32'h3000_0010, 32'h4000_0020);
    check("R4 pend from shift 0", statusOut, 32'h0000_0000);
    runOp(1'b0, 32'h0002_0100, 32'h3000_0010, 32'h4000_0020);
    check("R4 pend from shift 1", statusOut, 32'h0000_0080);
  endtask

  task automatic tNmiMask();
    runOp(1'b1, 32'h0000_0100, 32'h3000_0010, 32'h4000_0020);
    check("R5 rfn mask set", statusOut, 32'h0000_0200);
    runOp(1'b1, 32'h0000_0000, 32'h3000_0010, 32'h4000_0020);
    check("R5 rfn mask and pend", statusOut, 32'h0000_0280);
    runOp(1'b0, 32'h0008_0100, 32'h3000_0010, 32'h4000_0020);
    check("R6 rfe mask from shift", statusOut, 32'h0000_0200);
  endtask

  task automatic tTopBits();
    runOp(1'b0, 32'h3000_0100, 32'h3000_0010, 32'h4000_0020);
    check("R3 dropped pair", statusOut, 32'h0000_0000);
    runOp(1'b0, 32'hC000_0100, 32'h3000_0010, 32'h4000_0020);
    check("R3 kept pair", statusOut, 32'hC000_0000);
  endtask

  task automatic tHold();
    logic [31:0] s0, p0, k0;
    runOp(1'b0, 32'h0001_0000, 32'h5000_0004, 32'h6000_0008);
    check("R7 swap again sp", spOut, 32'h6000_0008);
    check("R7 swap again ksp", kspOut, 32'h5000_0004);
    s0 = statusOut; p0 = spOut; k0 = kspOut;
    @(negedge clk);
    isRfn = 1'b1; statusIn = 32'hFFFF_FFFF; spIn = 32'h7; uspIn = 32'h9;
    repeat (3) @(negedge clk);
    check("R9 status held", statusOut, s0);
    check("R9 sp held", spOut, p0);
    check("R9 ksp held", kspOut, k0);
  endtask

  initial begin
    #1;
    tReset();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFullShiftSwap();
    tPendForced();
    tPendNotForced();
    tNmiMask();
    tTopBits();
    tHold();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      finished = 1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=%08h expected=%08h", 32'h0, 32'h1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule